// File: doc/BRIEF.md
# Bidirectional I/O Port with Level Alarms

This block is a general-purpose I/O port of configurable width. Each bit has an output shadow flop, a direction flop and a synchronised input sample. A bit whose direction is output drives its shadow value onto the pad. A bit whose direction is input is not driven. Any bit can be watched for a high or a low level. A bit that is watched and sits at the watched level is reported as pending, and the single interrupt line is high while any bit is pending.

Software reaches the port through a one-word command interface. It presents an opcode and a bit mask with `cmd_valid` for one cycle. The port acts on the same clock edge. A registered response word, flagged by `rsp_valid`, follows in the next cycle. A small sequencer tracks the response. It has two states. `ST_IDLE` means no response is pending. `ST_RESP` means a response is on the port. The transitions are:
- **accept**: `ST_IDLE` to `ST_RESP` when a command arrives.
- **chain**: `ST_RESP` to `ST_RESP` when the next command follows at once.
- **drain**: `ST_RESP` to `ST_IDLE` when no command arrives.

Top module: `gpio_alarm_port`

## Requirements
- R1: After reset all bits are inputs (`gpio_oe` = 0), the output shadow `gpio_out` is 0, no alarm is armed, `alarm_pend` is 0, `irq` is 0 and `rsp_valid` is 0.
- R2: Opcode 3 (set bits) sets every shadow bit whose mask bit is 1 and leaves the other bits unchanged. Its response is the updated shadow.
- R3: Opcode 4 (clear bits) clears every shadow bit whose mask bit is 1 and leaves the other bits unchanged. Its response is the updated shadow.
- R4: Opcode 6 (make output) sets the direction bit (1 = output) of every masked bit and leaves the others unchanged. Its response is the output shadow. `gpio_oe` always equals the direction bits.
- R5: Opcode 5 (make input) clears the direction bit (0 = input) of every masked bit and leaves the others unchanged. Its response is the synchronised input level at the command edge.
- R6: Opcode 1 returns the synchronised input level and opcode 2 returns the output shadow. Neither changes any state.
- R7: A pin change is read or compared through two flops. A command taken at the first or second rising edge after the change still sees the old level. A command at the third edge sees the new level.
- R8: Opcode 7 arms a high-level watch and opcode 8 arms a low-level watch on the masked bits. Arming one polarity cancels the other polarity on the same bits. A bit is pending while it is armed and its synchronised level equals the armed level.
- R9: Opcode 9 disarms both polarities on the masked bits. `irq` is the OR of `alarm_pend`, so it stays high while any condition holds and falls once the alarms are cleared.
- R10: Every command raises `rsp_valid` for the cycle after its edge, with the response in `rsp_data`. Opcodes 7, 8 and 9 respond with 0. Opcode 0 and opcodes 10 to 15 change no state and respond with 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| cmd_valid | input | 1 | A command is presented this cycle |
| cmd_op | input | 4 | Command opcode |
| cmd_mask | input | WIDTH | Per-bit argument mask |
| rsp_valid | output | 1 | Response word valid |
| rsp_data | output | WIDTH | Response word |
| gpio_in | input | WIDTH | Raw pad input levels |
| gpio_out | output | WIDTH | Output shadow driven to pads |
| gpio_oe | output | WIDTH | Per-bit output enable (1 = drive) |
| alarm_pend | output | WIDTH | Per-bit alarm pending status |
| irq | output | 1 | Interrupt, OR of pending bits |

## Verification
The assertions assume that `cmd_valid` stays low while reset is applied. They also assume that `cmd_op` and `cmd_mask` are steady at the sampling edge, so that `$past` of the command lines matches what the sequencer acted on. The stimulus drives every command line on the falling edge and holds it for exactly one rising edge. Pad inputs change only on falling edges and are held for at least three rising edges before any alarm or read check, so the synchroniser has settled.

// File: rtl/gpio_alarm_pkg.sv
package gpio_alarm_pkg;

    typedef enum logic [3:0] {
        OP_NOP     = 4'd0,
        OP_RD_IN   = 4'd1,
        OP_RD_OUT  = 4'd2,
        OP_SET     = 4'd3,
        OP_CLR     = 4'd4,
        OP_MK_IN   = 4'd5,
        OP_MK_OUT  = 4'd6,
        OP_ARM_HI  = 4'd7,
        OP_ARM_LO  = 4'd8,
        OP_DISARM  = 4'd9
    } gpio_op_e;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_RESP = 1'b1
    } rsp_state_e;

endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
    parameter int WIDTH  = 8,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] raw,
    output logic [WIDTH-1:0] synced
);
    localparam int LAST = STAGES - 1;

    for (genvar b = 0; b < WIDTH; b++) begin : g_bit
        logic [STAGES-1:0] chain_q;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain_q <= '0;
            else        chain_q <= {chain_q[STAGES-2:0], raw[b]};
        end
        assign synced[b] = chain_q[LAST];
    end
endmodule

// File: rtl/gpio_alarm_bank.sv
module gpio_alarm_bank #(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             arm_hi_we,
    input  logic             arm_lo_we,
    input  logic             disarm_we,
    input  logic [WIDTH-1:0] mask,
    input  logic [WIDTH-1:0] level,
    output logic [WIDTH-1:0] pending
);
    logic [WIDTH-1:0] hi_q, lo_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hi_q <= '0;
            lo_q <= '0;
        end else if (arm_hi_we) begin
            hi_q <= hi_q | mask;
            lo_q <= lo_q & ~mask;
        end else if (arm_lo_we) begin
            lo_q <= lo_q | mask;
            hi_q <= hi_q & ~mask;
        end else if (disarm_we) begin
            hi_q <= hi_q & ~mask;
            lo_q <= lo_q & ~mask;
        end
    end

    assign pending = (hi_q & level) | (lo_q & ~level);
endmodule

// File: rtl/gpio_cmd_fsm.sv
module gpio_cmd_fsm
    import gpio_alarm_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cmd_valid,
    input  logic [3:0]       cmd_op,
    input  logic [WIDTH-1:0] cmd_mask,
    input  logic [WIDTH-1:0] level,
    output logic [WIDTH-1:0] shadow,
    output logic [WIDTH-1:0] dir,
    output logic             arm_hi_we,
    output logic             arm_lo_we,
    output logic             disarm_we,
    output logic             rsp_valid,
    output logic [WIDTH-1:0] rsp_data
);
    rsp_state_e       st_q, st_nxt;
    logic [WIDTH-1:0] shadow_q, dir_q, rsp_q;
    gpio_op_e         op;

    assign op = gpio_op_e'(cmd_op);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= ST_IDLE;
        else        st_q <= st_nxt;
    end

    always_comb begin
        st_nxt = st_q;
        unique case (st_q)
            ST_IDLE: if (cmd_valid)  st_nxt = ST_RESP;
            ST_RESP: if (!cmd_valid) st_nxt = ST_IDLE;
            default: st_nxt = ST_IDLE;
        endcase
    end

    assign arm_hi_we = cmd_valid && (op == OP_ARM_HI);
    assign arm_lo_we = cmd_valid && (op == OP_ARM_LO);
    assign disarm_we = cmd_valid && (op == OP_DISARM);

    // output and data registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            shadow_q <= '0;
            dir_q    <= '0;
            rsp_q    <= '0;
        end else if (cmd_valid) begin
            unique case (op)
                OP_RD_IN:  rsp_q <= level;
                OP_RD_OUT: rsp_q <= shadow_q;
                OP_SET: begin
                    shadow_q <= shadow_q | cmd_mask;
                    rsp_q    <= shadow_q | cmd_mask;
                end
                OP_CLR: begin
                    shadow_q <= shadow_q & ~cmd_mask;
                    rsp_q    <= shadow_q & ~cmd_mask;
                end
                OP_MK_IN: begin
                    dir_q <= dir_q & ~cmd_mask;
                    rsp_q <= level;
                end
                OP_MK_OUT: begin
                    dir_q <= dir_q | cmd_mask;
                    rsp_q <= shadow_q;
                end
                default: rsp_q <= '0;
            endcase
        end
    end

    assign shadow    = shadow_q;
    assign dir       = dir_q;
    assign rsp_data  = rsp_q;
    assign rsp_valid = (st_q == ST_RESP);
endmodule

// File: rtl/gpio_alarm_port.sv
module gpio_alarm_port #(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cmd_valid,
    input  logic [3:0]       cmd_op,
    input  logic [WIDTH-1:0] cmd_mask,
    output logic             rsp_valid,
    output logic [WIDTH-1:0] rsp_data,
    input  logic [WIDTH-1:0] gpio_in,
    output logic [WIDTH-1:0] gpio_out,
    output logic [WIDTH-1:0] gpio_oe,
    output logic [WIDTH-1:0] alarm_pend,
    output logic             irq
);
    localparam int SYNC_STAGES = 2;

    logic [WIDTH-1:0] level;
    logic             arm_hi_we, arm_lo_we, disarm_we;

    gpio_sync #(.WIDTH(WIDTH), .STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .raw(gpio_in), .synced(level)
    );

    gpio_cmd_fsm #(.WIDTH(WIDTH)) u_fsm (
        .clk(clk), .rst_n(rst_n),
        .cmd_valid(cmd_valid), .cmd_op(cmd_op), .cmd_mask(cmd_mask),
        .level(level), .shadow(gpio_out), .dir(gpio_oe),
        .arm_hi_we(arm_hi_we), .arm_lo_we(arm_lo_we), .disarm_we(disarm_we),
        .rsp_valid(rsp_valid), .rsp_data(rsp_data)
    );

    gpio_alarm_bank #(.WIDTH(WIDTH)) u_alarm (
        .clk(clk), .rst_n(rst_n),
        .arm_hi_we(arm_hi_we), .arm_lo_we(arm_lo_we), .disarm_we(disarm_we),
        .mask(cmd_mask), .level(level), .pending(alarm_pend)
    );

    assign irq = |alarm_pend;
endmodule

// File: rtl/gpio_alarm_port_chk.sv
module gpio_alarm_port_chk
    import gpio_alarm_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             cmd_valid,
    input logic [3:0]       cmd_op,
    input logic [WIDTH-1:0] cmd_mask,
    input logic             rsp_valid,
    input logic [WIDTH-1:0] gpio_out,
    input logic [WIDTH-1:0] gpio_oe,
    input logic [WIDTH-1:0] alarm_pend
);
    // R2
    set_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_op == OP_SET) |=> ((gpio_out & $past(cmd_mask)) == $past(cmd_mask)));

    // R3
    clr_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_op == OP_CLR) |=> ((gpio_out & $past(cmd_mask)) == '0));

    // R4
    make_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_op == OP_MK_OUT) |=> ((gpio_oe & $past(cmd_mask)) == $past(cmd_mask)));

    // R5
    make_in_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_op == OP_MK_IN) |=> ((gpio_oe & $past(cmd_mask)) == '0));

    // R9
    disarm_all_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_op == OP_DISARM && cmd_mask == '1) |=> (alarm_pend == '0));

    // R10
    rsp_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid |=> rsp_valid);

    // R10
    rsp_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !cmd_valid |=> !rsp_valid);

    // R6
    dir_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_op != OP_MK_IN && cmd_op != OP_MK_OUT) |=> $stable(gpio_oe));
endmodule

bind gpio_alarm_port gpio_alarm_port_chk #(.WIDTH(WIDTH)) u_chk (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .cmd_mask(cmd_mask), .rsp_valid(rsp_valid), .gpio_out(gpio_out),
    .gpio_oe(gpio_oe), .alarm_pend(alarm_pend)
);

// File: tb/sim_gpio_alarm_port.sv
module sim_gpio_alarm_port;
    localparam int  W        = 4;
    localparam time CLK_HALF = 5ns;
    localparam int  WD_LIMIT = 50000;
    localparam logic [W-1:0] ALL = '1;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         cmd_valid = 1'b0;
    logic [3:0]   cmd_op = '0;
    logic [W-1:0] cmd_mask = '0;
    logic [W-1:0] gpio_in = '0;
    logic         rsp_valid, irq;
    logic [W-1:0] rsp_data, gpio_out, gpio_oe, alarm_pend;

    int n_chk = 0, n_bad = 0, cyc = 0;
    logic [W-1:0] m_out = '0, m_dir = '0, m_hi = '0, m_lo = '0, m_pin = '0;

    always #CLK_HALF clk = ~clk;

    gpio_alarm_port #(.WIDTH(W)) u0 (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
        .cmd_mask(cmd_mask), .rsp_valid(rsp_valid), .rsp_data(rsp_data),
        .gpio_in(gpio_in), .gpio_out(gpio_out), .gpio_oe(gpio_oe),
        .alarm_pend(alarm_pend), .irq(irq)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    function automatic logic [W-1:0] exp_pend();
        return (m_hi & m_pin) | (m_lo & ~m_pin);
    endfunction

    // called at a falling edge; returns at the falling edge after the command edge
    task automatic do_cmd(input logic [3:0] op, input logic [W-1:0] m);
        cmd_valid = 1'b1; cmd_op = op; cmd_mask = m;
        @(posedge clk); @(negedge clk);
        cmd_valid = 1'b0; cmd_op = '0; cmd_mask = '0;
    endtask

    task automatic check_state(input string tag);
        chk({tag, " out"}, 32'(gpio_out), 32'(m_out));
        chk({tag, " oe"}, 32'(gpio_oe), 32'(m_dir));
        chk({tag, " pend"}, 32'(alarm_pend), 32'(exp_pend()));
        chk({tag, " irq"}, 32'(irq), 32'(exp_pend() != '0));
    endtask

    task automatic set_pins(input logic [W-1:0] p);
        gpio_in = p; m_pin = p;
        repeat (3) @(negedge clk);
    endtask

    task automatic finish_run();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    endtask

    initial begin
        forever begin
            @(posedge clk);
            cyc++;
            if (cyc > WD_LIMIT) begin
                n_chk++; n_bad++;
                $display("FAIL watchdog: actual %0d cycles expected < %0d", cyc, WD_LIMIT);
                finish_run();
            end
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk("R1 oe", 32'(gpio_oe), 0);
        chk("R1 out", 32'(gpio_out), 0);
        chk("R1 pend", 32'(alarm_pend), 0);
        chk("R1 irq", 32'(irq), 0);
        chk("R1 rsp_valid", 32'(rsp_valid), 0);

        // R2 / R3 sweep of set and clear masks
        for (int m = 0; m < 16; m++) begin
            logic [W-1:0] sm = W'(m);
            logic [W-1:0] cm = W'((m * 3 + 1) % 16);
            do_cmd(4'd3, sm);
            m_out = m_out | sm;
            chk("R2 rsp", 32'(rsp_data), 32'(m_out));
            chk("R10 valid", 32'(rsp_valid), 1);
            check_state("R2");
            do_cmd(4'd4, cm);
            m_out = m_out & ~cm;
            chk("R3 rsp", 32'(rsp_data), 32'(m_out));
            check_state("R3");
        end
        @(negedge clk);
        chk("R10 valid drops", 32'(rsp_valid), 0);

        // R4 / R5 direction sweep
        set_pins(4'hA);
        for (int m = 0; m < 16; m++) begin
            logic [W-1:0] om = W'((m * 5 + 2) % 16);
            logic [W-1:0] im = W'((m * 7 + 3) % 16);
            do_cmd(4'd6, om);
            m_dir = m_dir | om;
            chk("R4 rsp", 32'(rsp_data), 32'(m_out));
            check_state("R4");
            do_cmd(4'd5, im);
            m_dir = m_dir & ~im;
            chk("R5 rsp", 32'(rsp_data), 32'(m_pin));
            check_state("R5");
        end

        // R6 reads leave state alone
        do_cmd(4'd3, 4'h5); m_out = m_out | 4'h5;
        do_cmd(4'd2, ALL);
        chk("R6 rd_out", 32'(rsp_data), 32'(m_out));
        check_state("R6 rd_out");
        do_cmd(4'd1, ALL);
        chk("R6 rd_in", 32'(rsp_data), 32'(m_pin));
        check_state("R6 rd_in");

        // R7 synchroniser latency: old, old, new
        gpio_in = 4'h3;
        do_cmd(4'd1, '0);
        chk("R7 edge1", 32'(rsp_data), 32'(m_pin));
        do_cmd(4'd1, '0);
        chk("R7 edge2", 32'(rsp_data), 32'(m_pin));
        do_cmd(4'd1, '0);
        m_pin = 4'h3;
        chk("R7 edge3", 32'(rsp_data), 32'(m_pin));

        // R8 / R9 alarm sweep
        for (int k = 0; k < 16; k++) begin
            logic [W-1:0] hm = W'(k);
            logic [W-1:0] lm = W'((k * 5 + 1) % 16);
            logic [W-1:0] dm = W'((k * 3 + 2) % 16);
            set_pins(W'((k * 3 + 7) % 16));
            do_cmd(4'd9, ALL); m_hi = '0; m_lo = '0;
            chk("R9 clear rsp", 32'(rsp_data), 0);
            check_state("R9 clear");
            do_cmd(4'd7, hm); m_hi = m_hi | hm; m_lo = m_lo & ~hm;
            chk("R8 hi rsp", 32'(rsp_data), 0);
            check_state("R8 hi");
            do_cmd(4'd8, lm); m_lo = m_lo | lm; m_hi = m_hi & ~lm;
            check_state("R8 lo");
            set_pins(~m_pin);
            check_state("R8 pin flip");
            do_cmd(4'd9, dm); m_hi = m_hi & ~dm; m_lo = m_lo & ~dm;
            check_state("R9 partial");
        end
        do_cmd(4'd7, ALL); m_hi = ALL; m_lo = '0;
        check_state("R9 irq set");
        do_cmd(4'd9, ALL); m_hi = '0;
        chk("R9 irq drop", 32'(irq), 0);

        // R10 unused opcodes change nothing and return 0
        do_cmd(4'd8, 4'h6); m_lo = 4'h6;
        for (int op = 10; op < 17; op++) begin
            logic [3:0] uop = (op == 16) ? 4'd0 : 4'(op);
            do_cmd(uop, ALL);
            chk("R10 unused rsp", 32'(rsp_data), 0);
            check_state("R10 unused");
        end

        finish_run();
    end
endmodule